// File: doc/BRIEF.md
# Raster Timing Generator with Double-Buffered Parameters

This block produces the line and frame timing for a parallel pixel display. Two counters walk each line and each frame. From their positions the block drives a horizontal sync, a vertical sync, a data-enable strobe and the coordinates of the pixel being shown. Each line is split into four parts: the visible pixels, then a front porch, then the sync pulse, then a back porch. A frame is split into lines the same way. Software can invert the level of each of the three strobes on its own.

Software sets the eight timing fields through a small word-addressed register port. These writes land in a pending copy and do not change the timing that is running. A load request copies the pending set into the working set. If the generator is stopped, the copy happens at once. If it is running, the copy waits for the end of the current frame. The load request then clears itself. Clearing the run bit lets the frame in progress finish before the block goes idle, and the run bit reads back as set until that happens. A vertical-blank event sets a status flag that software clears by writing 1 to it. The interrupt output is that flag masked by an enable bit. A soft-reset bit holds both counters at the start of a frame and keeps the strobes inactive.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, the strobes are inactive: hsync, vsync and de are low, and irq is low. pix_x and pix_y are 0. The control word (address 0) reads 0, and every timing field (addresses 1 to 8) reads 1.
- R2: A line lasts HA+HFP+HS+HBP cycles. hsync is active during cycles HA+HFP up to HA+HFP+HS-1 of the line. The fields are HA at address 1, HFP at 2, HS at 3 and HBP at 4.
- R3: A frame lasts VA+VFP+VS+VBP lines. vsync is active for the whole of lines VA+VFP up to VA+VFP+VS-1. The fields are VA at address 5, VFP at 6, VS at 7 and VBP at 8.
- R4: de is active only when the line position is below HA and the line number is below VA. While de is active, pix_x and pix_y equal the line position and the line number. Otherwise both are 0.
- R5: Control bits 3, 4 and 5 invert hsync, vsync and de. An inversion takes effect in the cycle after the write. When stopped, each strobe sits at its inactive level.
- R6: A write to a timing field does not change the running timing. Setting control bit 1 (load) while running copies the pending fields at the next frame end. Bit 1 reads 1 until the copy happens and 0 after it. Reading a timing field returns the pending value.
- R7: A load requested while stopped is applied on the next cycle.
- R8: When control bit 0 (run) is set while stopped, the first pixel (de active, position 0,0) appears two cycles after the write cycle.
- R9: When run is cleared while running, the current frame finishes. Bit 0 reads 1 until the stop, and after the last cycle of the frame the outputs go idle and bit 0 reads 0.
- R10: The vertical-blank status (address 9, bit 0) becomes 1 one cycle after the counters reach position 0 of line VA. Writing 1 to it clears it.
- R11: irq equals the status bit AND the enable bit (address 10, bit 0).
- R12: While control bit 2 (soft reset) is 1, the strobes are inactive and the counters return to the frame start. After release, output resumes at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | CW | Pixel column while de is active |
| pix_y | output | CW | Pixel line while de is active |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The bench keeps a cycle-level model of line and frame position and compares every strobe, coordinate and the interrupt on every cycle. Two timing sets with different totals and porch lengths are used, so a miscounted porch or a boundary that is off by one shows up as a shifted edge. Pending writes are made in mid-frame both with and without a load request. This separates timing that must stay unchanged from a copy that must land exactly at the frame end. Polarity, soft reset and a deferred stop are each applied while the generator is running. This shows that inversion is immediate, that soft reset restarts the frame, and that a stop waits for the last line.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          irq
);
  localparam int TW = CW + 2;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd9, A_IEN = 4'd10;

  logic [CW-1:0] sh [8];
  logic [CW-1:0] wk [8];
  logic run_req, running, load_pend, srst, inv_hs, inv_vs, inv_de, vb_stat, vb_en;
  logic [TW-1:0] hcnt, vcnt;
  logic [TW-1:0] h_a, h_s0, h_s1, h_tot, v_a, v_s0, v_s1, v_tot;

  assign h_a   = TW'(wk[0]);
  assign h_s0  = h_a  + TW'(wk[1]);
  assign h_s1  = h_s0 + TW'(wk[2]);
  assign h_tot = h_s1 + TW'(wk[3]);
  assign v_a   = TW'(wk[4]);
  assign v_s0  = v_a  + TW'(wk[5]);
  assign v_s1  = v_s0 + TW'(wk[6]);
  assign v_tot = v_s1 + TW'(wk[7]);

  logic live, line_end, frame_end, vb_hit, apply, ctrl_wr;
  assign live      = running & ~srst;
  assign line_end  = hcnt == h_tot - 1'b1;
  assign frame_end = live & line_end & (vcnt == v_tot - 1'b1);
  assign vb_hit    = live & (hcnt == '0) & (vcnt == v_a);
  assign apply     = load_pend & (~running | frame_end);
  assign ctrl_wr   = reg_we & (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        sh[i] <= CW'(1);
        wk[i] <= CW'(1);
      end
      {run_req, running, load_pend, srst} <= '0;
      {inv_hs, inv_vs, inv_de, vb_stat, vb_en} <= '0;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      for (int i = 0; i < 8; i++)
        if (reg_we && reg_addr == 4'(i + 1)) sh[i] <= reg_wdata[CW-1:0];

      if (apply) begin
        for (int i = 0; i < 8; i++) wk[i] <= sh[i];
        load_pend <= 1'b0;
      end
      if (ctrl_wr) begin
        run_req <= reg_wdata[0];
        srst    <= reg_wdata[2];
        inv_hs  <= reg_wdata[3];
        inv_vs  <= reg_wdata[4];
        inv_de  <= reg_wdata[5];
        if (reg_wdata[1]) load_pend <= 1'b1;
      end
      if (reg_we && reg_addr == A_IEN) vb_en <= reg_wdata[0];

      if (vb_hit) vb_stat <= 1'b1;
      else if (reg_we && reg_addr == A_STAT && reg_wdata[0]) vb_stat <= 1'b0;

      if (frame_end) begin
        if (!run_req) running <= 1'b0;
      end else if (srst && !run_req) begin
        running <= 1'b0;
      end else if (!running && run_req) begin
        running <= 1'b1;
      end

      if (!live) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (line_end) begin
        hcnt <= '0;
        vcnt <= (vcnt == v_tot - 1'b1) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  logic hs_raw, vs_raw, de_raw;
  assign hs_raw = live & (hcnt >= h_s0) & (hcnt < h_s1);
  assign vs_raw = live & (vcnt >= v_s0) & (vcnt < v_s1);
  assign de_raw = live & (hcnt < h_a) & (vcnt < v_a);

  assign hsync = hs_raw ^ inv_hs;
  assign vsync = vs_raw ^ inv_vs;
  assign de    = de_raw ^ inv_de;
  assign pix_x = de_raw ? hcnt[CW-1:0] : '0;
  assign pix_y = de_raw ? vcnt[CW-1:0] : '0;
  assign irq   = vb_stat & vb_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = DW'({inv_de, inv_vs, inv_hs, srst, load_pend, run_req | running});
      A_STAT: reg_rdata = DW'(vb_stat);
      A_IEN:  reg_rdata = DW'(vb_en);
      default:
        for (int i = 0; i < 8; i++)
          if (reg_addr == 4'(i + 1)) reg_rdata = DW'(sh[i]);
    endcase
  end
endmodule

module raster_timing_gen_chk #(
  parameter int CW = 12,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            running,
  input logic            srst,
  input logic            frame_end,
  input logic            load_pend,
  input logic            vb_hit,
  input logic            vb_stat,
  input logic [CW+1:0]   hcnt,
  input logic [CW+1:0]   vcnt,
  input logic [CW+1:0]   h_tot,
  input logic [CW+1:0]   v_tot,
  input logic            reg_we,
  input logic [3:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [CW-1:0]   pix_x,
  input logic [CW-1:0]   pix_y
);
  p_idle_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pix_x == '0 && pix_y == '0));

  p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hcnt < h_tot));

  p_vcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (vcnt < v_tot));

  p_load_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pend && frame_end && !(reg_we && reg_addr == 4'd0 && reg_wdata[1])) |=> !load_pend);

  p_start_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (hcnt == '0 && vcnt == '0));

  p_stop_deferred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end && !srst) |=> running);

  p_vblank_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vb_hit |=> vb_stat);
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CW(CW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .srst(srst),
  .frame_end(frame_end), .load_pend(load_pend), .vb_hit(vb_hit),
  .vb_stat(vb_stat), .hcnt(hcnt), .vcnt(vcnt), .h_tot(h_tot), .v_tot(v_tot),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic hsync, vsync, de, irq;
  logic [CW-1:0] pix_x, pix_y;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.CW(CW), .DW(DW)) i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cur [8];
  int pend [8];
  int cfg_a [8] = '{4, 2, 3, 1, 3, 1, 2, 1};
  int cfg_b [8] = '{6, 1, 2, 3, 4, 2, 1, 2};
  bit pend_m = 0, run_m = 0, runreq_m = 0, srst_m = 0;
  bit ihs = 0, ivs = 0, ide = 0, st_m = 0, en_m = 0, mon_on = 0;
  int eh = 0, ev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    bit live, e_de, e_hs, e_vs;
    int hs0, hs1, htot, vs0, vs1, vtot;
    live = run_m && !srst_m;
    hs0 = cur[0] + cur[1]; hs1 = hs0 + cur[2]; htot = hs1 + cur[3];
    vs0 = cur[4] + cur[5]; vs1 = vs0 + cur[6]; vtot = vs1 + cur[7];
    e_de = live && eh < cur[0] && ev < cur[4];
    e_hs = live && eh >= hs0 && eh < hs1;
    e_vs = live && ev >= vs0 && ev < vs1;
    chk(hsync == (e_hs ^ ihs), "R2/R5 hsync", int'(hsync), int'(e_hs ^ ihs));
    chk(vsync == (e_vs ^ ivs), "R3/R5 vsync", int'(vsync), int'(e_vs ^ ivs));
    chk(de == (e_de ^ ide), "R4/R5 de", int'(de), int'(e_de ^ ide));
    chk(int'(pix_x) == (e_de ? eh : 0), "R4 pix_x", int'(pix_x), e_de ? eh : 0);
    chk(int'(pix_y) == (e_de ? ev : 0), "R4 pix_y", int'(pix_y), e_de ? ev : 0);
    chk(irq == (st_m && en_m), "R10/R11 irq", int'(irq), int'(st_m && en_m));
    if (live && eh == 0 && ev == cur[4]) st_m = 1;
    if (!run_m) begin
      if (pend_m) begin cur = pend; pend_m = 0; end
      if (runreq_m) run_m = 1;
      eh = 0; ev = 0;
    end else if (srst_m) begin
      if (!runreq_m) run_m = 0;
      eh = 0; ev = 0;
    end else if (eh == htot - 1) begin
      eh = 0;
      if (ev == vtot - 1) begin
        ev = 0;
        if (pend_m) begin cur = pend; pend_m = 0; end
        if (!runreq_m) run_m = 0;
      end else ev++;
    end else eh++;
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    int d;
    @(negedge clk);
    chk(hsync == 0 && vsync == 0 && de == 0, "R1 strobes", int'({hsync, vsync, de}), 0);
    chk(irq == 0 && pix_x == 0 && pix_y == 0, "R1 irq/xy", int'(irq) + int'(pix_x) + int'(pix_y), 0);
    rd(4'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4'd1, d); chk(d == 1, "R1 field1", d, 1);
    rd(4'd8, d); chk(d == 1, "R1 field8", d, 1);
  endtask

  task automatic t_basic;
    int d;
    for (int i = 0; i < 8; i++) wr(4'(i + 1), cfg_a[i]);
    pend = cfg_a;
    wr(4'd0, 32'h2);
    pend_m = 1;
    mon_on = 1;
    cycles(2);
    rd(4'd0, d); chk(d == 0, "R7 load cleared while idle", d, 0);
    chk(cur[0] == 4, "R7 idle load applied", cur[0], 4);
    wr(4'd0, 32'h1);
    runreq_m = 1;
    @(negedge clk);
    chk(de == 0, "R8 not yet started", int'(de), 0);
    @(negedge clk);
    chk(de == 1 && pix_x == 0 && pix_y == 0, "R8 first pixel", int'(de), 1);
    cycles(140);
  endtask

  task automatic t_polarity;
    wr(4'd0, 32'h39);
    ihs = 1; ivs = 1; ide = 1;
    cycles(75);
    wr(4'd0, 32'h1);
    ihs = 0; ivs = 0; ide = 0;
    cycles(5);
  endtask

  task automatic t_shadow;
    int d;
    wait (ev == 1);
    for (int i = 0; i < 8; i++) wr(4'(i + 1), cfg_b[i]);
    pend = cfg_b;
    rd(4'd1, d); chk(d == 6, "R6 pending readback", d, 6);
    wait (ev == 0);
    wait (ev == 2);
    chk(cur[0] == 4, "R6 timing unchanged without load", cur[0], 4);
    wait (ev == 1);
    wr(4'd0, 32'h3);
    pend_m = 1;
    rd(4'd0, d); chk(d == 3, "R6 load pending reads 1", d, 3);
    wait (pend_m == 0);
    cycles(2);
    rd(4'd0, d); chk(d == 1, "R6 load cleared at frame end", d, 1);
    cycles(120);
  endtask

  task automatic t_irq;
    int d;
    wr(4'd10, 1);
    en_m = 1;
    wait (st_m == 1);
    cycles(2);
    rd(4'd9, d); chk(d == 1, "R10 status set", d, 1);
    wr(4'd9, 1);
    st_m = 0;
    @(negedge clk);
    chk(irq == 0, "R10 write-1 clear", int'(irq), 0);
    wr(4'd10, 0);
    en_m = 0;
    wait (st_m == 1);
    cycles(3);
    chk(irq == 0, "R11 masked irq", int'(irq), 0);
    rd(4'd9, d); chk(d == 1, "R11 status held while masked", d, 1);
    wr(4'd9, 1);
    st_m = 0;
  endtask

  task automatic t_srst;
    wait (ev == 1 && eh == 3);
    wr(4'd0, 32'h5);
    srst_m = 1;
    cycles(20);
    chk(de == 0 && hsync == 0 && vsync == 0, "R12 outputs idle", int'({hsync, vsync, de}), 0);
    wr(4'd0, 32'h1);
    srst_m = 0;
    @(negedge clk);
    chk(de == 1 && pix_x == 0 && pix_y == 0, "R12 restart at origin", int'(pix_x) + int'(pix_y), 0);
    cycles(60);
  endtask

  task automatic t_stop;
    int d;
    wait (ev == 2);
    wr(4'd0, 32'h0);
    runreq_m = 0;
    rd(4'd0, d); chk(d == 1, "R9 run reads 1 during stop", d, 1);
    wait (run_m == 0);
    cycles(2);
    rd(4'd0, d); chk(d == 0, "R9 run reads 0 after stop", d, 0);
    cycles(10);
    chk(de == 0 && pix_x == 0, "R9 idle after stop", int'(de), 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur = '{1, 1, 1, 1, 1, 1, 1, 1};
    pend = cur;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_polarity();
    t_shadow();
    t_irq();
    t_srst();
    t_stop();
    mon_on = 0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule